// File: doc/BRIEF.md
# Shift-Add Factored Matrix-Vector Engine

This block multiplies a vector of `N` signed fixed-point samples by a constant matrix that has been stored as a chain of sparse square factors. The first factor (stage 0, the codebook stage) and up to `MAX_L` further factors (the wiring stages 1..L) each give every output row at most two terms. Every term is a source element of the previous vector shifted left by 0 to 7 places and optionally negated. No multiplier is present. Each output row is therefore one adder, and a single pair of term units plus that adder is reused for every row of every stage.

Software fills the factor descriptors and the stage count through a write port while the engine is idle. Each vector then enters through a valid/ready handshake. The stages run one row per clock over a double-buffered working vector held at a width that cannot overflow. The result goes out through a second valid/ready handshake, saturated to `OUT_W` bits. A per-vector accumulate flag adds the new product to the previous unsaturated result. This lets a matrix that was split column-wise into sub-blocks be summed over several input sub-vectors.

Top module: `pow2_mvm`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_data is all zero. Every descriptor is invalid, the stage count is 1 and the order is forward.
- R2: A descriptor is written as cfg_desc = {valid, negate, shift[2:0], src[IDX_W-1:0]}, MSB first, where IDX_W = log2(N) and N is a power of two. A valid slot contributes (negate ? -1 : 1) * (v[src] << shift) to its row. An invalid slot contributes 0, so a row with both slots invalid yields 0.
- R3: Each row of each stage is the sum of its two slots, selected by cfg_slot 0 or 1. Both slots may name the same source.
- R4: In forward order (len_rev = 0), stage 0 is applied first and then stages 1..L in increasing order. Every stage reads only the vector produced by the stage before it, even for rows already rewritten in the current stage.
- R5: With len_rev = 1, the stages run L, L-1, ..., 1 and then stage 0.
- R6: len_val sets L. A value of 0 is taken as 1, and a value above MAX_L is taken as MAX_L.
- R7: Intermediate values never overflow. Each output element is the exact result saturated to the signed OUT_W range ([-512, 511] by default).
- R8: When in_accum is 1 on the accepted input, the result is the previous unsaturated result plus the new product. When in_accum is 0, the result replaces the previous one.
- R9: After the accepting edge, in_ready is 0 and out_valid first reads 1 exactly (L+1)*N+1 clock edges later.
- R10: out_valid and out_data hold steady until out_ready is seen. On the next cycle out_valid is 0 and in_ready is 1.
- R11: Descriptor and stage-count writes presented while the engine is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_stage | input | 3 | Stage of the descriptor (0 = codebook) |
| cfg_row | input | 2 | Destination row |
| cfg_slot | input | 1 | Slot within the row |
| cfg_desc | input | 7 | {valid, negate, shift[2:0], src[1:0]} |
| len_we | input | 1 | Stage-count write strobe |
| len_val | input | 3 | Requested L |
| len_rev | input | 1 | 1 selects reverse stage order |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Engine idle, ready for a vector |
| in_data | input | 32 | N signed samples, element i at [i*8 +: 8] |
| in_accum | input | 1 | Add to the previous result |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| out_data | output | 40 | N saturated results, element i at [i*10 +: 10] |

## Verification
The hardest situation to reach is a stage whose later rows read sources that earlier rows of the same stage have already rewritten. Only the double buffer keeps those reads on the old values, and the difference shows only after the remaining stages have mixed the data. Directed factors make a wiring row read a source whose row was rewritten earlier in the same stage. They also use a non-commuting rotation stage with both orders, so a swapped buffer or a wrong stage order changes the outputs. The bench also writes configuration in the middle of a computation and then repeats the same vector, checking that both the result and the latency are unchanged. Random factor chains with random lengths, orders and accumulate flags fill in the remaining combinations.

// File: rtl/pow2_mvm_pkg.sv
package pow2_mvm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/pow2_coef_bank.sv
// Descriptor storage: NSTG stages x N rows x 2 slots.
module pow2_coef_bank #(
  parameter int N      = 4,
  parameter int NSTG   = 5,
  parameter int STG_W  = 3,
  parameter int ROW_W  = 2,
  parameter int DESC_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [STG_W-1:0]           wr_stage,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic                       wr_slot,
  input  logic [DESC_W-1:0]          wr_desc,
  input  logic [STG_W-1:0]           rd_stage,
  input  logic [ROW_W-1:0]           rd_row,
  output logic [1:0][DESC_W-1:0]     rd_pair
);
  localparam int DEPTH = NSTG * N * 2;

  logic [DEPTH-1:0][DESC_W-1:0] mem_q;
  int wr_idx;
  int rd_idx;
  logic wr_ok;

  always_comb begin
    wr_idx = (int'(wr_stage) * N + int'(wr_row)) * 2 + int'(wr_slot);
    rd_idx = (int'(rd_stage) * N + int'(rd_row)) * 2;
    wr_ok  = wr_en && (int'(wr_stage) < NSTG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_ok) begin
      mem_q[wr_idx] <= wr_desc;
    end
  end

  always_comb begin
    rd_pair[0] = '0;
    rd_pair[1] = '0;
    if (rd_idx < DEPTH - 1) begin
      rd_pair[0] = mem_q[rd_idx];
      rd_pair[1] = mem_q[rd_idx + 1];
    end
  end

  // R11: storage only changes on an accepted write
  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/pow2_term.sv
// One signed power-of-two term: select, shift, optional negate.
module pow2_term #(
  parameter int N       = 4,
  parameter int ACC_W   = 49,
  parameter int IDX_W   = 2,
  parameter int SHIFT_W = 3,
  parameter int DESC_W  = 7
) (
  input  logic [DESC_W-1:0]        desc,
  input  logic [N*ACC_W-1:0]       vec,
  output logic signed [ACC_W-1:0]  term
);
  logic [IDX_W-1:0]          src;
  logic [SHIFT_W-1:0]        sh;
  logic                      neg;
  logic                      vld;
  logic signed [ACC_W-1:0]   x;
  logic signed [ACC_W-1:0]   xs;

  always_comb begin
    src  = desc[IDX_W-1:0];
    sh   = desc[IDX_W +: SHIFT_W];
    neg  = desc[IDX_W+SHIFT_W];
    vld  = desc[DESC_W-1];
    x    = vec[int'(src)*ACC_W +: ACC_W];
    xs   = x <<< sh;
    if (!vld)     term = '0;
    else if (neg) term = -xs;
    else          term = xs;
  end
endmodule

// File: rtl/pow2_sat.sv
module pow2_sat #(
  parameter int IN_W  = 53,
  parameter int OUT_W = 10
) (
  input  logic signed [IN_W-1:0]  din,
  output logic [OUT_W-1:0]        dout
);
  localparam logic signed [IN_W-1:0] MAXV = IN_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [IN_W-1:0] MINV = -MAXV - IN_W'(1);

  always_comb begin
    if (din > MAXV)      dout = MAXV[OUT_W-1:0];
    else if (din < MINV) dout = MINV[OUT_W-1:0];
    else                 dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/pow2_mvm.sv
module pow2_mvm #(
  parameter int N         = 4,
  parameter int DATA_W    = 8,
  parameter int OUT_W     = 10,
  parameter int MAX_L     = 4,
  parameter int SHIFT_W   = 3,
  parameter int ACC_GUARD = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [$clog2(MAX_L+1)-1:0]    cfg_stage,
  input  logic [$clog2(N)-1:0]          cfg_row,
  input  logic                          cfg_slot,
  input  logic [$clog2(N)+SHIFT_W+1:0]  cfg_desc,
  input  logic                          len_we,
  input  logic [$clog2(MAX_L+1)-1:0]    len_val,
  input  logic                          len_rev,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [N*DATA_W-1:0]           in_data,
  input  logic                          in_accum,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [N*OUT_W-1:0]            out_data
);
  import pow2_mvm_pkg::*;

  localparam int IDX_W  = $clog2(N);
  localparam int STG_W  = $clog2(MAX_L+1);
  localparam int NSTG   = MAX_L + 1;
  localparam int DESC_W = IDX_W + SHIFT_W + 2;
  localparam int MAX_SH = (1 << SHIFT_W) - 1;
  // each stage grows magnitude by at most 2^(MAX_SH+1); one extra sign bit
  localparam int ACC_W  = DATA_W + NSTG * (MAX_SH + 1) + 1;
  localparam int RES_W  = ACC_W + ACC_GUARD;

  // ---------------- reset: async assert, sync release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // ---------------- control state
  phase_t             phase_q, phase_d;
  logic [IDX_W-1:0]   row_q, row_d;
  logic [STG_W-1:0]   step_q, step_d;
  logic               cur_q, cur_d;
  logic               acc_q;
  logic [STG_W-1:0]   len_q, len_clamped;
  logic               rev_q;
  logic               idle, accept, last_row, last_step, run_en, fin_en;
  logic [STG_W-1:0]   cur_stage;

  assign idle      = (phase_q == PH_IDLE);
  assign accept    = idle && in_valid;
  assign run_en    = (phase_q == PH_RUN);
  assign fin_en    = (phase_q == PH_FIN);
  assign last_row  = (row_q == IDX_W'(N-1));
  assign last_step = (step_q == len_q);
  assign cur_stage = rev_q ? (len_q - step_q) : step_q;
  assign in_ready  = idle;
  assign out_valid = (phase_q == PH_DONE);

  always_comb begin
    if (len_val == '0)                  len_clamped = STG_W'(1);
    else if (int'(len_val) > MAX_L)     len_clamped = STG_W'(MAX_L);
    else                                len_clamped = len_val;
  end

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    step_d  = step_q;
    cur_d   = cur_q;
    unique case (phase_q)
      PH_IDLE: if (in_valid) begin
        phase_d = PH_RUN;
        row_d   = '0;
        step_d  = '0;
        cur_d   = 1'b0;
      end
      PH_RUN: begin
        if (last_row) begin
          row_d = '0;
          cur_d = ~cur_q;
          if (last_step) phase_d = PH_FIN;
          else           step_d  = step_q + STG_W'(1);
        end else begin
          row_d = row_q + IDX_W'(1);
        end
      end
      PH_FIN:  phase_d = PH_DONE;
      PH_DONE: if (out_ready) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      step_q  <= '0;
      cur_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      step_q  <= step_d;
      cur_q   <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      acc_q <= 1'b0;
    end else if (accept) begin
      acc_q <= in_accum;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      len_q <= STG_W'(1);
      rev_q <= 1'b0;
    end else if (len_we && idle) begin
      len_q <= len_clamped;
      rev_q <= len_rev;
    end
  end

  // ---------------- coefficient storage
  logic [1:0][DESC_W-1:0] slot_desc;

  pow2_coef_bank #(
    .N(N), .NSTG(NSTG), .STG_W(STG_W), .ROW_W(IDX_W), .DESC_W(DESC_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (cfg_we && idle),
    .wr_stage (cfg_stage),
    .wr_row   (cfg_row),
    .wr_slot  (cfg_slot),
    .wr_desc  (cfg_desc),
    .rd_stage (cur_stage),
    .rd_row   (row_q),
    .rd_pair  (slot_desc)
  );

  // ---------------- working vector, double buffered
  logic [N*ACC_W-1:0] wbuf_q [2];
  logic [N*ACC_W-1:0] in_ext;
  logic [N*ACC_W-1:0] cur_vec;

  for (genvar gi = 0; gi < N; gi++) begin : g_ext
    assign in_ext[gi*ACC_W +: ACC_W] =
      {{(ACC_W-DATA_W){in_data[gi*DATA_W+DATA_W-1]}}, in_data[gi*DATA_W +: DATA_W]};
  end

  assign cur_vec = wbuf_q[cur_q];

  logic signed [ACC_W-1:0] term [2];
  for (genvar gs = 0; gs < 2; gs++) begin : g_slot
    pow2_term #(
      .N(N), .ACC_W(ACC_W), .IDX_W(IDX_W), .SHIFT_W(SHIFT_W), .DESC_W(DESC_W)
    ) u_term (
      .desc (slot_desc[gs]),
      .vec  (cur_vec),
      .term (term[gs])
    );
  end

  logic signed [ACC_W:0] row_sum;
  assign row_sum = {term[0][ACC_W-1], term[0]} + {term[1][ACC_W-1], term[1]};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wbuf_q[0] <= '0;
      wbuf_q[1] <= '0;
    end else if (accept) begin
      wbuf_q[0] <= in_ext;
    end else if (run_en) begin
      wbuf_q[~cur_q][int'(row_q)*ACC_W +: ACC_W] <= row_sum[ACC_W-1:0];
    end
  end

  // ---------------- result, accumulate, saturate
  for (genvar gr = 0; gr < N; gr++) begin : g_res
    logic signed [RES_W-1:0] res_q;
    logic signed [RES_W-1:0] add_in;
    assign add_in = {{(RES_W-ACC_W){cur_vec[gr*ACC_W+ACC_W-1]}}, cur_vec[gr*ACC_W +: ACC_W]};

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
        res_q <= '0;
      end else if (fin_en) begin
        res_q <= (acc_q ? res_q : '0) + add_in;
      end
    end

    pow2_sat #(.IN_W(RES_W), .OUT_W(OUT_W)) u_sat (
      .din  (res_q),
      .dout (out_data[gr*OUT_W +: OUT_W])
    );
  end

  // ---------------- assertions
  // R7: guard bits suffice, the adder never carries past ACC_W
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_i_n)
    run_en |-> (row_sum[ACC_W] == row_sum[ACC_W-1]));
  // R9: after accepting a vector the input side closes
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && in_ready) |=> !in_ready);
  // R10: result is held until consumed
  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R10: consumption returns the engine to idle
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
  // R1: handshake sides never open together
  a_r1_sides_exclusive: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(in_ready && out_valid));
endmodule

// File: tb/pow2_mvm_bench.sv
module pow2_mvm_bench;
  localparam int N = 4, DW = 8, OW = 10, ML = 4;
  localparam longint OMAX = 511, OMIN = -512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_slot = 0, len_we = 0, len_rev = 0;
  logic [2:0] cfg_stage = 0, len_val = 0;
  logic [1:0] cfg_row = 0;
  logic [6:0] cfg_desc = 0;
  logic in_valid = 0, in_accum = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [N*DW-1:0] in_data = '0;
  logic [N*OW-1:0] out_data;

  always #5 clk = ~clk;

  pow2_mvm u_pow2_mvm (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_row(cfg_row),
    .cfg_slot(cfg_slot), .cfg_desc(cfg_desc), .len_we(len_we), .len_val(len_val),
    .len_rev(len_rev), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_accum(in_accum), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // reference model state
  int m_vld[5][4][2], m_neg[5][4][2], m_sh[5][4][2], m_src[5][4][2];
  int m_len = 1, m_rev = 0;
  longint m_res[4], vin[4], expo[4];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clampo(input longint v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  task automatic model_run(input bit acc);
    longint v[4], nv[4], t;
    int s;
    for (int i = 0; i < N; i++) v[i] = vin[i];
    for (int k = 0; k <= m_len; k++) begin
      s = m_rev ? (m_len - k) : k;
      for (int r = 0; r < N; r++) begin
        nv[r] = 0;
        for (int sl = 0; sl < 2; sl++) if (m_vld[s][r][sl] != 0) begin
          t = v[m_src[s][r][sl]] <<< m_sh[s][r][sl];
          if (m_neg[s][r][sl] != 0) t = -t;
          nv[r] += t;
        end
      end
      for (int r = 0; r < N; r++) v[r] = nv[r];
    end
    for (int i = 0; i < N; i++) begin
      m_res[i] = acc ? (m_res[i] + v[i]) : v[i];
      expo[i] = clampo(m_res[i]);
    end
  endtask

  task automatic wdesc(input int s, input int r, input int sl, input int vld,
                       input int neg, input int sh, input int src);
    @(negedge clk);
    cfg_we = 1; cfg_stage = 3'(s); cfg_row = 2'(r); cfg_slot = sl[0];
    cfg_desc = {vld[0], neg[0], 3'(sh), 2'(src)};
    m_vld[s][r][sl] = vld; m_neg[s][r][sl] = neg; m_sh[s][r][sl] = sh; m_src[s][r][sl] = src;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_len(input int l, input int rev);
    @(negedge clk);
    len_we = 1; len_val = 3'(l); len_rev = rev[0];
    m_len = (l == 0) ? 1 : (l > ML ? ML : l);
    m_rev = rev;
    @(negedge clk);
    len_we = 0;
  endtask

  task automatic run_vec(input string tag, input bit acc, input bit poke);
    int lat;
    longint got;
    logic [N*OW-1:0] held;
    model_run(acc);
    @(negedge clk);
    for (int i = 0; i < N; i++) in_data[i*DW +: DW] = 8'(vin[i]);
    in_valid = 1; in_accum = acc;
    check(in_ready == 1, "R9 ready before accept", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check(in_ready == 0, "R9 busy after accept", in_ready, 0);
    lat = 0;
    while (!out_valid && lat < 200) begin
      if (poke && lat == 1) begin
        cfg_we = 1; cfg_stage = 0; cfg_row = 0; cfg_slot = 0; cfg_desc = 7'h00;
        len_we = 1; len_val = 3'd4; len_rev = 1;
      end
      if (poke && lat == 2) begin cfg_we = 0; len_we = 0; end
      @(posedge clk); lat++;
      @(negedge clk);
    end
    cfg_we = 0; len_we = 0;
    check(lat == (m_len + 1) * N + 1, "R9 latency", lat, (m_len + 1) * N + 1);
    for (int i = 0; i < N; i++) begin
      got = $signed(out_data[i*OW +: OW]);
      check(got == expo[i], tag, got, expo[i]);
    end
    held = out_data;
    @(posedge clk); @(negedge clk);
    check(out_valid && out_data == held, "R10 hold", out_valid, 1);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    out_ready = 0;
    check(in_ready && !out_valid, "R10 release", in_ready, 1);
  endtask

  task automatic set_vin(input longint a, input longint b, input longint c, input longint d);
    vin[0] = a; vin[1] = b; vin[2] = c; vin[3] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de));
    for (int s = 0; s < 5; s++) for (int r = 0; r < 4; r++) for (int sl = 0; sl < 2; sl++) begin
      m_vld[s][r][sl] = 0; m_neg[s][r][sl] = 0; m_sh[s][r][sl] = 0; m_src[s][r][sl] = 0;
    end
    for (int i = 0; i < N; i++) m_res[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(in_ready == 1, "R1 in_ready", in_ready, 1);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(out_data == '0, "R1 out_data", out_data, 0);

    // R2: codebook identity, wiring rotation with negate and shift, zero row 3
    for (int r = 0; r < 4; r++) wdesc(0, r, 0, 1, 0, 0, r);
    for (int r = 0; r < 3; r++) wdesc(1, r, 0, 1, 1, 1, (r + 1) % 4);
    set_vin(10, -20, 30, -7);
    run_vec("R2 terms and zero row", 0, 0);

    // R3: same source twice in one row
    wdesc(1, 0, 0, 1, 0, 1, 2);
    wdesc(1, 0, 1, 1, 0, 0, 2);
    // R4: row 1 reads row 0's source, which row 0 rewrites earlier in the same stage
    wdesc(1, 1, 0, 1, 0, 0, 0);
    run_vec("R3 R4 duplicate source and old-vector read", 0, 0);

    // R4 / R5: non-commuting rotation in stage 2, both orders
    for (int r = 0; r < 4; r++) wdesc(2, r, 0, 1, 0, r % 2, (r + 3) % 4);
    set_len(2, 0);
    set_vin(3, -5, 7, 11);
    run_vec("R4 forward order", 0, 0);
    set_len(2, 1);
    run_vec("R5 reverse order", 0, 0);

    // R6: length clamping
    for (int s = 3; s < 5; s++) for (int r = 0; r < 4; r++) wdesc(s, r, 0, 1, 0, 0, r);
    set_len(0, 0);
    run_vec("R6 len 0 as 1", 0, 0);
    set_len(7, 0);
    run_vec("R6 len above max", 0, 0);

    // R7: negative full scale, driven past both output limits
    set_len(1, 0);
    for (int r = 0; r < 4; r++) begin
      wdesc(1, r, 0, 1, (r >= 2) ? 1 : 0, 3, r);
      wdesc(1, r, 1, 0, 0, 0, 0);
    end
    set_vin(-128, -128, -128, -128);
    run_vec("R7 saturation", 0, 0);
    set_vin(-128, 1, -128, 1);
    run_vec("R7 mixed saturation", 0, 0);

    // R8: accumulate across sub-blocks
    set_vin(5, -6, 7, -8);
    run_vec("R8 first partial", 0, 0);
    set_vin(-1, 2, 3, 4);
    run_vec("R8 accumulated", 1, 0);
    set_vin(100, 100, -100, -100);
    run_vec("R8 accumulate into saturation", 1, 0);

    // R11: writes while busy are ignored (same result and latency afterwards)
    set_vin(9, -3, 4, 12);
    run_vec("R11 before busy write", 0, 1);
    run_vec("R11 after busy write", 0, 0);

    // random factor chains (R2 R3 R4 R5 R8)
    for (int it = 0; it < 40; it++) begin
      for (int s = 0; s < 5; s++) for (int r = 0; r < 4; r++) for (int sl = 0; sl < 2; sl++)
        wdesc(s, r, sl, ($urandom_range(0, 3) != 0) ? 1 : 0, $urandom_range(0, 1),
              ($urandom_range(0, 7) == 0) ? $urandom_range(0, 7) : $urandom_range(0, 2),
              $urandom_range(0, 3));
      set_len($urandom_range(0, 7), $urandom_range(0, 1));
      for (int i = 0; i < N; i++) vin[i] = longint'($urandom_range(0, 255)) - 128;
      run_vec("R4 random chain", (it % 3 == 2), 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule